// File: doc/BRIEF.md
# Dual-Write Dual-Read Synchronous RAM with Collision Arbitration

This block is a synchronous memory of 512 words, each 18 bits wide. It has two write ports and two read ports, and all four can work in the same clock cycle. Each write port carries two lane enables. Lane 0 covers bits 8:0 of the word and lane 1 covers bits 17:9, so a port can update one half of a word and leave the other half as it was.

When both write ports target the same word and enable at least one common lane, that lane is in collision. A configuration input selects how a collision is handled. With arbitration on, port A takes the contested lanes and port B's write to those lanes is discarded. With arbitration off, the contested lanes become undefined; simulation stores X there. Collisions are checked lane by lane, so two writes to different lanes of one word both complete. A registered flag reports every collision one cycle later, whatever the arbitration setting.

Reads take one cycle. A read that hits a word being written in the same cycle returns the value stored before that write.

Top module: `qp_ram`

## Requirements
- R1: While `rst` is high, both read outputs and `coll` are driven to zero on every clock edge, and they hold zero in the first cycle after `rst` falls.
- R2: A full-word write (`w?_be` = 2'b11) is stored, and a read of that address presented at one edge shows the data on the read output after that edge.
- R3: Lane enable bit 0 updates only bits 8:0 and bit 1 updates only bits 17:9; the lanes that are not enabled keep their previous contents.
- R4: A read of an address that is written at the same edge returns the old data; the new data appears on the next read.
- R5: The two write ports store to different addresses in the same cycle, and the two read ports return different addresses in the same cycle.
- R6: With `arb_en`=1, when both ports write the same address with a common lane enabled, port A's data is stored in every common lane and port B's data is stored only in lanes that B alone enables.
- R7: Writes from both ports to the same address with no common lane both take effect, and `coll` stays low.
- R8: `coll` is high for exactly the one cycle after an edge at which both ports write the same address with at least one common lane, and is low otherwise.
- R9: With `arb_en`=0, a same-address, same-lane collision raises `coll`, while writes to other addresses still store correctly.
- R10: A port with `w?_en`=0, or with `w?_be`=2'b00, changes no stored data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| arb_en | input | 1 | 1: port A wins contested lanes; 0: contested lanes undefined |
| wa_en | input | 1 | Write port A enable |
| wa_addr | input | 9 | Write port A address |
| wa_be | input | 2 | Write port A lane enables (bit0: 8:0, bit1: 17:9) |
| wa_data | input | 18 | Write port A data |
| wb_en | input | 1 | Write port B enable |
| wb_addr | input | 9 | Write port B address |
| wb_be | input | 2 | Write port B lane enables |
| wb_data | input | 18 | Write port B data |
| ra_addr | input | 9 | Read port A address |
| ra_data | output | 18 | Read port A data, one cycle after the address |
| rb_addr | input | 9 | Read port B address |
| rb_data | output | 18 | Read port B data, one cycle after the address |
| coll | output | 1 | One-cycle pulse after a write collision |

## Verification
The assertions check the collision flag on every cycle: it may only pulse after an overlapping write, and it must stay low after every edge that has none. Within each lane they also confirm that both ports never store to the same word at once. The reset values of the outputs are checked too. What is actually stored can only be shown by the bench's scenarios: the sweep over every address, lane masking, read-during-write ordering, and which port's data survives a collision.

// File: rtl/qp_ram_pkg.sv
package qp_ram_pkg;
  localparam int unsigned QP_DEPTH_DEF  = 512;
  localparam int unsigned QP_LANE_W_DEF = 9;
  localparam int unsigned QP_LANES_DEF  = 2;

  // Policy for lanes that both ports write at once.
  typedef enum logic {
    COLL_POISON = 1'b0,
    COLL_A_WINS = 1'b1
  } coll_mode_e;
endpackage

// File: rtl/qp_ram_arb.sv
module qp_ram_arb
  import qp_ram_pkg::*;
#(
  parameter int unsigned AW    = 9,
  parameter int unsigned LANES = 2
) (
  input  logic             rst,
  input  logic             arb_en,
  input  logic             a_en,
  input  logic [AW-1:0]    a_addr,
  input  logic [LANES-1:0] a_be,
  input  logic             b_en,
  input  logic [AW-1:0]    b_addr,
  input  logic [LANES-1:0] b_be,
  output logic [LANES-1:0] a_we,
  output logic [LANES-1:0] b_we,
  output logic [LANES-1:0] a_poison,
  output logic             hit
);
  coll_mode_e       mode;
  logic             same_word;
  logic [LANES-1:0] overlap;

  always_comb begin
    mode      = arb_en ? COLL_A_WINS : COLL_POISON;
    same_word = a_en && b_en && (a_addr == b_addr);
    overlap   = same_word ? (a_be & b_be) : '0;
    hit       = !rst && (|overlap);
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_comb begin
      a_we[g]     = !rst && a_en && a_be[g];
      // B never stores into a contested lane; A carries it (data or X).
      b_we[g]     = !rst && b_en && b_be[g] && !overlap[g];
      a_poison[g] = overlap[g] && (mode == COLL_POISON);
    end
  end
endmodule

// File: rtl/qp_ram_lane.sv
module qp_ram_lane #(
  parameter int unsigned DEPTH = 512,
  parameter int unsigned W     = 9,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we_a,
  input  logic          poison_a,
  input  logic [AW-1:0] addr_a,
  input  logic [W-1:0]  d_a,
  input  logic          we_b,
  input  logic [AW-1:0] addr_b,
  input  logic [W-1:0]  d_b,
  input  logic [AW-1:0] rd_addr_a,
  input  logic [AW-1:0] rd_addr_b,
  output logic [W-1:0]  q_a,
  output logic [W-1:0]  q_b
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we_a) mem[addr_a] <= poison_a ? {W{1'bx}} : d_a;
    if (we_b) mem[addr_b] <= d_b;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      q_a <= '0;
      q_b <= '0;
    end else begin
      q_a <= mem[rd_addr_a];
      q_b <= mem[rd_addr_b];
    end
  end

  // R6: the arbiter never lets both ports store into one word of a lane.
  p_one_writer_r6: assert property (@(posedge clk) disable iff (rst)
    (we_a && we_b) |-> (addr_a != addr_b));
endmodule

// File: rtl/qp_ram.sv
module qp_ram
  import qp_ram_pkg::*;
#(
  parameter int unsigned DEPTH  = QP_DEPTH_DEF,
  parameter int unsigned LANE_W = QP_LANE_W_DEF,
  parameter int unsigned LANES  = QP_LANES_DEF,
  localparam int unsigned AW    = $clog2(DEPTH),
  localparam int unsigned DW    = LANE_W * LANES
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             arb_en,
  input  logic             wa_en,
  input  logic [AW-1:0]    wa_addr,
  input  logic [LANES-1:0] wa_be,
  input  logic [DW-1:0]    wa_data,
  input  logic             wb_en,
  input  logic [AW-1:0]    wb_addr,
  input  logic [LANES-1:0] wb_be,
  input  logic [DW-1:0]    wb_data,
  input  logic [AW-1:0]    ra_addr,
  output logic [DW-1:0]    ra_data,
  input  logic [AW-1:0]    rb_addr,
  output logic [DW-1:0]    rb_data,
  output logic             coll
);
  logic [LANES-1:0] a_we, b_we, a_poison;
  logic             hit;

  qp_ram_arb #(.AW(AW), .LANES(LANES)) u_arb (
    .rst      (rst),
    .arb_en   (arb_en),
    .a_en     (wa_en),
    .a_addr   (wa_addr),
    .a_be     (wa_be),
    .b_en     (wb_en),
    .b_addr   (wb_addr),
    .b_be     (wb_be),
    .a_we     (a_we),
    .b_we     (b_we),
    .a_poison (a_poison),
    .hit      (hit)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    qp_ram_lane #(.DEPTH(DEPTH), .W(LANE_W)) u_lane (
      .clk       (clk),
      .rst       (rst),
      .we_a      (a_we[g]),
      .poison_a  (a_poison[g]),
      .addr_a    (wa_addr),
      .d_a       (wa_data[g*LANE_W +: LANE_W]),
      .we_b      (b_we[g]),
      .addr_b    (wb_addr),
      .d_b       (wb_data[g*LANE_W +: LANE_W]),
      .rd_addr_a (ra_addr),
      .rd_addr_b (rb_addr),
      .q_a       (ra_data[g*LANE_W +: LANE_W]),
      .q_b       (rb_data[g*LANE_W +: LANE_W])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) coll <= 1'b0;
    else     coll <= hit;
  end

  // R1: outputs leave reset at zero.
  p_rst_clear_r1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (ra_data == '0 && rb_data == '0 && !coll));

  // R8: a flag pulse must follow a same-word, shared-lane write.
  p_coll_src_r8: assert property (@(posedge clk) disable iff (rst)
    coll |-> $past(wa_en && wb_en && (wa_addr == wb_addr) && (|(wa_be & wb_be))));

  // R8/R7: no shared lane at this edge, no flag in the next cycle.
  p_coll_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    !(wa_en && wb_en && (wa_addr == wb_addr) && (|(wa_be & wb_be))) |=> !coll);
endmodule

// File: tb/tb_qp_ram.sv
`timescale 1ns/1ps
module tb_qp_ram;
  localparam int N = 512;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        arb_en = 1'b1;
  logic        wa_en = 1'b0, wb_en = 1'b0;
  logic [8:0]  wa_addr = '0, wb_addr = '0, ra_addr = '0, rb_addr = '0;
  logic [1:0]  wa_be = '0, wb_be = '0;
  logic [17:0] wa_data = '0, wb_data = '0;
  logic [17:0] ra_data, rb_data;
  logic        coll;

  int total = 0;
  int bad   = 0;
  bit done  = 0;
  logic [17:0] model [N];

  always #2.5 clk = ~clk;

  qp_ram dut (
    .clk(clk), .rst(rst), .arb_en(arb_en),
    .wa_en(wa_en), .wa_addr(wa_addr), .wa_be(wa_be), .wa_data(wa_data),
    .wb_en(wb_en), .wb_addr(wb_addr), .wb_be(wb_be), .wb_data(wb_data),
    .ra_addr(ra_addr), .ra_data(ra_data), .rb_addr(rb_addr), .rb_data(rb_data),
    .coll(coll)
  );

  function automatic logic [17:0] pat(int a, int s);
    return 18'((a * 37 + s * 1013 + 5) % 262144);
  endfunction

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(string req, logic [17:0] act, logic [17:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle();
    wa_en = 0; wb_en = 0; wa_be = 0; wb_be = 0;
  endtask

  task automatic rd(int a, logic [17:0] exp, string req);
    ra_addr = 9'(a); rb_addr = 9'(a);
    tick();
    chk(req, ra_data, exp);
    chk(req, rb_data, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #1;
    // R1: reset state
    ra_addr = 9'd3; rb_addr = 9'd4;
    tick(); tick();
    chk("R1", ra_data, '0); chk("R1", rb_data, '0); chk("R1", {17'd0, coll}, '0);
    rst = 0;
    chk("R1", ra_data, '0); chk("R1", {17'd0, coll}, '0);

    // R5/R2: fill all words, both ports to different halves
    for (int i = 0; i < N/2; i++) begin
      wa_en = 1; wa_be = 2'b11; wa_addr = 9'(i);       wa_data = pat(i, 1);
      wb_en = 1; wb_be = 2'b11; wb_addr = 9'(i + N/2); wb_data = pat(i + N/2, 1);
      model[i] = pat(i, 1); model[i + N/2] = pat(i + N/2, 1);
      tick();
      chk("R8", {17'd0, coll}, '0);
    end
    idle();

    // R2/R5: sweep both read ports over different addresses
    for (int i = 0; i < N; i++) begin
      ra_addr = 9'(i); rb_addr = 9'(N - 1 - i);
      tick();
      chk("R2", ra_data, model[i]);
      chk("R5", rb_data, model[N - 1 - i]);
    end

    // R3: lane masking on each port
    wa_en = 1; wa_be = 2'b01; wa_addr = 9'd10; wa_data = 18'h2AAAA;
    model[10][8:0] = 9'h0AA;
    tick(); idle();
    wb_en = 1; wb_be = 2'b10; wb_addr = 9'd11; wb_data = 18'h15555;
    model[11][17:9] = 9'h0AA;
    tick(); idle();
    rd(10, model[10], "R3");
    rd(11, model[11], "R3");

    // R10: disabled port and empty lane mask change nothing
    wa_en = 0; wa_be = 2'b11; wa_addr = 9'd12; wa_data = 18'h3FFFF;
    wb_en = 1; wb_be = 2'b00; wb_addr = 9'd13; wb_data = 18'h3FFFF;
    tick(); idle();
    rd(12, model[12], "R10");
    rd(13, model[13], "R10");

    // R4: read during write returns the old word
    ra_addr = 9'd20; rb_addr = 9'd20;
    wa_en = 1; wa_be = 2'b11; wa_addr = 9'd20; wa_data = 18'h12345;
    tick(); idle();
    chk("R4", ra_data, model[20]);
    model[20] = 18'h12345;
    tick();
    chk("R4", ra_data, model[20]);

    // R6/R8: arbitration on, full overlap -> A wins, one-cycle flag
    arb_en = 1;
    wa_en = 1; wa_be = 2'b11; wa_addr = 9'd30; wa_data = 18'h0F0F0;
    wb_en = 1; wb_be = 2'b11; wb_addr = 9'd30; wb_data = 18'h30303;
    model[30] = 18'h0F0F0;
    tick(); idle();
    chk("R8", {17'd0, coll}, 18'd1);
    tick();
    chk("R8", {17'd0, coll}, 18'd0);
    rd(30, model[30], "R6");

    // R6: partial overlap -> lane0 from A, lane1 from B
    wa_en = 1; wa_be = 2'b01; wa_addr = 9'd31; wa_data = 18'h00111;
    wb_en = 1; wb_be = 2'b11; wb_addr = 9'd31; wb_data = 18'h3FE22;
    model[31] = {9'h1FF, 9'h111};
    tick(); idle();
    chk("R8", {17'd0, coll}, 18'd1);
    rd(31, model[31], "R6");

    // R7: disjoint lanes at one address, both stored, no flag
    wa_en = 1; wa_be = 2'b01; wa_addr = 9'd32; wa_data = 18'h00155;
    wb_en = 1; wb_be = 2'b10; wb_addr = 9'd32; wb_data = 18'h2AA00;
    model[32] = {9'h155, 9'h155};
    tick(); idle();
    chk("R7", {17'd0, coll}, 18'd0);
    rd(32, model[32], "R7");

    // R9: arbitration off, collision flagged; other writes still land
    arb_en = 0;
    wa_en = 1; wa_be = 2'b11; wa_addr = 9'd40; wa_data = 18'h11111;
    wb_en = 1; wb_be = 2'b11; wb_addr = 9'd40; wb_data = 18'h22222;
    tick(); idle();
    chk("R9", {17'd0, coll}, 18'd1);
    wa_en = 1; wa_be = 2'b11; wa_addr = 9'd41; wa_data = 18'h0ABCD;
    wb_en = 1; wb_be = 2'b11; wb_addr = 9'd42; wb_data = 18'h1DCBA;
    model[41] = 18'h0ABCD; model[42] = 18'h1DCBA;
    tick(); idle();
    chk("R9", {17'd0, coll}, 18'd0);
    rd(41, model[41], "R9");
    rd(42, model[42], "R9");

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule